// File: doc/BRIEF.md
# SECDED-Protected RAM Wrapper with Partial-Write Merge

This block wraps a word-organised RAM in which every 64-bit data word is stored next to an 8-bit single-error-correct, double-error-detect code. A simple request/ready bus reaches three regions: the data words, an alias window that exposes each word's stored check byte, and a small set of control and status registers. Full-width writes encode and store the new word directly. Narrower writes fetch the old word, verify it, merge the enabled byte lanes and store the re-encoded result. Reads correct single-bit faults on the returned data and answer uncorrectable words with an error response.

Software can inject faults on purpose. It turns checking off, enables check-byte writes, and writes a check byte with one or two bits inverted. A word that holds a double-bit fault keeps failing every read and every partial write until a full-width write replaces it. Faults are recorded in sticky status flags, in a saturating counter of corrected events and in an address register that clears when it is read.

Top module: `ecc_ram_wrapper`

## Requirements
- R1: A data write with all eight byte enables set stores the word with freshly computed check bits and does not read the old contents. `bus_ready` rises one cycle after acceptance with no error. This removes any earlier double-bit fault at that word.
- R2: A data write with some byte enables clear is a read-modify-write. Byte lane i (`bus_wdata[8i+7:8i]`, enable `bus_be[i]`) replaces the old lane, and the other lanes keep their old values. `bus_ready` rises two cycles after acceptance.
- R3: When the read phase of a read-modify-write finds a double-bit fault, the response carries `bus_err`, nothing is stored, and the fault is logged as for R5.
- R4: A data read answers two cycles after acceptance. When checking is on, a single-bit fault in either the data or the check bits is corrected in `bus_rdata` with no error. The stored word is not repaired, so the same fault appears on every later read.
- R5: When checking is on, a data read that finds a double-bit fault answers with `bus_err`. Every later read of that word faults the same way until an R1 write replaces it.
- R6: Region 1 (`bus_addr[7:6]`=01 at the default size) maps the check byte of word n to `bus_rdata[7:0]`. A write stores `bus_wdata[7:0]` only when `bus_be[0]` is set, check-byte writes are enabled and checking is off. Otherwise the write is ignored. Inverting one stored check bit gives a corrected fault; inverting two gives an uncorrectable fault.
- R7: The control register sits at region 2, index 0. Bits [3:0] control checking and bits [7:4] control check-byte writes. In each field, 0xA turns the setting on, 0x5 turns it off, and any other value leaves it unchanged. A read returns 0xA or 0x5 in each field. The reset value is 0x5A (checking on, check-byte writes off).
- R8: The status register sits at region 2, index 1. Bit 0 is a sticky corrected-fault flag, bit 1 is a sticky uncorrectable-fault flag, and bits [15:8] count corrected faults, saturating at 255. Writing 1 to bit 0 clears that flag and the counter. Writing 1 to bit 1 clears that flag. The reset value is 0.
- R9: The fault address register sits at region 2, index 2. Bit 31 is a valid flag and the low bits hold the word address of the most recent uncorrectable fault. A read returns the value and then clears it. The reset value is 0.
- R10: While checking is off, data reads return the stored bits unaltered, never carry `bus_err` and leave status untouched.
- R11: `bus_ready` is a one-cycle pulse, and `bus_err` is only asserted together with it. Register accesses and check-byte writes answer one cycle after acceptance, and check-byte reads answer after two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Request, held with its fields until `bus_ready` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W+2 | Word address; the top two bits select the region (0 data, 1 check alias, 2 registers) |
| bus_be | input | 8 | Byte lane enables for writes |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid with `bus_ready` |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_err | output | 1 | Error response, valid with `bus_ready` |

## Verification
The bench builds the wrapper with the default ADDR_W of 6, which gives 64 data words and an 8-bit word address. With this size the alias region and the register region have short literal addresses, and words at the bottom, in the middle and at the top of the array can all be used in one short run. Because the array is small, one word can be held in a corrected-fault state and read more than 255 times, so saturation of the corrected-fault counter is reached within the cycle budget. Faults are injected only through the check-byte window, so the expected data never depends on the bench knowing the code itself.

// File: rtl/ecc_ram_pkg.sv
package ecc_ram_pkg;

    localparam int DATA_W   = 64;
    localparam int CHK_W    = 8;
    localparam int HAM_W    = 7;
    localparam int CODE_TOP = 71;
    localparam int LANES    = DATA_W / 8;

    localparam logic [3:0] KEY_ON  = 4'hA;
    localparam logic [3:0] KEY_OFF = 4'h5;

    typedef enum logic [1:0] {
        RG_DATA = 2'd0,
        RG_CHK  = 2'd1,
        RG_CSR  = 2'd2,
        RG_NONE = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_RESP = 2'd2
    } state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              sec;
        logic              ded;
    } dec_res_t;

    // Hamming parity: every data bit sits at a non power-of-two code
    // position; each parity bit is the XOR of positions sharing its bit.
    function automatic logic [HAM_W-1:0] ham_par(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] p;
        logic [5:0]       idx;
        p   = '0;
        idx = '0;
        for (int pos = 1; pos <= CODE_TOP; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                if (d[idx]) p = p ^ pos[HAM_W-1:0];
                idx = idx + 6'd1;
            end
        end
        return p;
    endfunction

    function automatic logic [CHK_W-1:0] secded_encode(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] p;
        p = ham_par(d);
        return {^{d, p}, p};
    endfunction

    // Flip the data bit that lives at code position syn (if any).
    function automatic logic [DATA_W-1:0] flip_at(input logic [DATA_W-1:0] d,
                                                  input logic [HAM_W-1:0] syn);
        logic [DATA_W-1:0] r;
        logic [5:0]        idx;
        r   = d;
        idx = '0;
        for (int pos = 1; pos <= CODE_TOP; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                if (pos[HAM_W-1:0] == syn) r[idx] = ~r[idx];
                idx = idx + 6'd1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/ecc_secded_enc.sv
module ecc_secded_enc
    import ecc_ram_pkg::*;
(
    input  logic [DATA_W-1:0] din,
    output logic [CHK_W-1:0]  chk
);
    assign chk = secded_encode(din);
endmodule

// File: rtl/ecc_secded_dec.sv
module ecc_secded_dec
    import ecc_ram_pkg::*;
(
    input  logic [DATA_W-1:0] din,
    input  logic [CHK_W-1:0]  cin,
    output dec_res_t          res
);
    logic [HAM_W-1:0] syn;
    logic             odd;
    logic             syn_pow2;

    assign syn      = ham_par(din) ^ cin[HAM_W-1:0];
    assign odd      = ^{din, cin};
    assign syn_pow2 = ((syn & (syn - 7'd1)) == '0);

    always_comb begin
        res.data = din;
        res.sec  = 1'b0;
        res.ded  = 1'b0;
        if (odd) begin
            if (syn > HAM_W'(CODE_TOP)) begin
                res.ded = 1'b1;
            end else begin
                res.sec = 1'b1;
                if (!syn_pow2) res.data = flip_at(din, syn);
            end
        end else if (syn != '0) begin
            res.ded = 1'b1;
        end
    end
endmodule

// File: rtl/ecc_ram_store.sv
module ecc_ram_store
    import ecc_ram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              we_data,
    input  logic              we_chk,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CHK_W-1:0]  wchk,
    output logic [DATA_W-1:0] rdata,
    output logic [CHK_W-1:0]  rchk
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] data_mem [WORDS];
    logic [CHK_W-1:0]  chk_mem  [WORDS];

    always_ff @(posedge clk) begin
        if (we_data) data_mem[addr] <= wdata;
        if (we_chk)  chk_mem[addr]  <= wchk;
        if (rd_en) begin
            rdata <= data_mem[addr];
            rchk  <= chk_mem[addr];
        end
    end
endmodule

// File: rtl/ecc_ram_csr.sv
module ecc_ram_csr
    import ecc_ram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic              stat_wr,
    input  logic              ue_rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sec_evt,
    input  logic              ded_evt,
    input  logic [ADDR_W-1:0] ded_addr,
    output logic              ecc_on,
    output logic              chk_wr_on,
    output logic [7:0]        sec_cnt,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [DATA_W-1:0] stat_word,
    output logic [DATA_W-1:0] ue_word
);
    logic              sec_flag;
    logic              ded_flag;
    logic              ue_valid;
    logic [ADDR_W-1:0] ue_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ecc_on    <= 1'b1;
            chk_wr_on <= 1'b0;
            sec_flag  <= 1'b0;
            ded_flag  <= 1'b0;
            sec_cnt   <= '0;
            ue_valid  <= 1'b0;
            ue_addr   <= '0;
        end else begin
            if (ctrl_wr) begin
                if (wdata[3:0] == KEY_ON)       ecc_on <= 1'b1;
                else if (wdata[3:0] == KEY_OFF) ecc_on <= 1'b0;
                if (wdata[7:4] == KEY_ON)       chk_wr_on <= 1'b1;
                else if (wdata[7:4] == KEY_OFF) chk_wr_on <= 1'b0;
            end
            if (stat_wr && wdata[0]) begin
                sec_flag <= 1'b0;
                sec_cnt  <= '0;
            end else if (sec_evt) begin
                sec_flag <= 1'b1;
                if (sec_cnt != 8'hFF) sec_cnt <= sec_cnt + 8'd1;
            end
            if (stat_wr && wdata[1]) ded_flag <= 1'b0;
            else if (ded_evt)        ded_flag <= 1'b1;
            if (ded_evt) begin
                ue_valid <= 1'b1;
                ue_addr  <= ded_addr;
            end else if (ue_rd) begin
                ue_valid <= 1'b0;
                ue_addr  <= '0;
            end
        end
    end

    assign ctrl_word = {56'h0, chk_wr_on ? KEY_ON : KEY_OFF, ecc_on ? KEY_ON : KEY_OFF};
    assign stat_word = {48'h0, sec_cnt, 6'h0, ded_flag, sec_flag};
    assign ue_word   = {32'h0, ue_valid, 31'(ue_addr)};
endmodule

// File: rtl/ecc_ram_wrapper.sv
module ecc_ram_wrapper
    import ecc_ram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W+1:0] bus_addr,
    input  logic [7:0]        bus_be,
    input  logic [63:0]       bus_wdata,
    output logic [63:0]       bus_rdata,
    output logic              bus_ready,
    output logic              bus_err
);
    localparam int AW = ADDR_W + 2;

    state_e            state_q, state_d;
    region_e           in_region, rq_region;
    logic              accept;
    logic              r_we;
    logic [ADDR_W-1:0] r_word;
    logic [LANES-1:0]  r_be;
    logic [DATA_W-1:0] r_wdata;

    logic [ADDR_W-1:0] st_addr;
    logic              st_we_data, st_we_chk;
    logic [DATA_W-1:0] st_wdata, st_rdata;
    logic [CHK_W-1:0]  st_wchk, st_rchk;

    logic [DATA_W-1:0] enc_din;
    logic [CHK_W-1:0]  enc_chk;
    dec_res_t          dec_res;

    logic              ctrl_wr, stat_wr, ue_rd, sec_evt, ded_evt;
    logic              ecc_on, chk_wr_on;
    logic [7:0]        sec_cnt;
    logic [DATA_W-1:0] ctrl_word, stat_word, ue_word;

    logic [DATA_W-1:0] base, merged, rdata_d, rdata_q;
    logic              err_d, err_q, load_resp;

    assign accept    = (state_q == ST_IDLE) && bus_req;
    assign in_region = region_e'(bus_addr[AW-1:ADDR_W]);

    ecc_ram_store #(.ADDR_W(ADDR_W)) u_store (
        .clk(clk), .addr(st_addr), .rd_en(accept),
        .we_data(st_we_data), .we_chk(st_we_chk),
        .wdata(st_wdata), .wchk(st_wchk),
        .rdata(st_rdata), .rchk(st_rchk)
    );

    ecc_secded_enc u_enc (.din(enc_din), .chk(enc_chk));
    ecc_secded_dec u_dec (.din(st_rdata), .cin(st_rchk), .res(dec_res));

    ecc_ram_csr #(.ADDR_W(ADDR_W)) u_csr (
        .clk(clk), .rst(rst),
        .ctrl_wr(ctrl_wr), .stat_wr(stat_wr), .ue_rd(ue_rd),
        .wdata(bus_wdata), .sec_evt(sec_evt), .ded_evt(ded_evt),
        .ded_addr(r_word), .ecc_on(ecc_on), .chk_wr_on(chk_wr_on),
        .sec_cnt(sec_cnt), .ctrl_word(ctrl_word),
        .stat_word(stat_word), .ue_word(ue_word)
    );

    // Old word as seen by the merge: corrected when checking is on.
    assign base = ecc_on ? dec_res.data : st_rdata;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign merged[8*g +: 8] = r_be[g] ? r_wdata[8*g +: 8] : base[8*g +: 8];
        end
    endgenerate

    always_comb begin
        state_d    = state_q;
        st_addr    = accept ? bus_addr[ADDR_W-1:0] : r_word;
        st_we_data = 1'b0;
        st_we_chk  = 1'b0;
        enc_din    = bus_wdata;
        st_wdata   = bus_wdata;
        st_wchk    = enc_chk;
        ctrl_wr    = 1'b0;
        stat_wr    = 1'b0;
        ue_rd      = 1'b0;
        sec_evt    = 1'b0;
        ded_evt    = 1'b0;
        rdata_d    = '0;
        err_d      = 1'b0;
        load_resp  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (bus_req) begin
                    state_d   = ST_RESP;
                    load_resp = 1'b1;
                    unique case (in_region)
                        RG_DATA: begin
                            if (bus_we && (bus_be == '1)) begin
                                st_we_data = 1'b1;
                                st_we_chk  = 1'b1;
                            end else begin
                                state_d   = ST_LOOK;
                                load_resp = 1'b0;
                            end
                        end
                        RG_CHK: begin
                            if (bus_we) begin
                                if (chk_wr_on && !ecc_on && bus_be[0]) begin
                                    st_we_chk = 1'b1;
                                    st_wchk   = bus_wdata[CHK_W-1:0];
                                end
                            end else begin
                                state_d   = ST_LOOK;
                                load_resp = 1'b0;
                            end
                        end
                        RG_CSR: begin
                            unique case (bus_addr[1:0])
                                2'd0: begin
                                    ctrl_wr = bus_we;
                                    if (!bus_we) rdata_d = ctrl_word;
                                end
                                2'd1: begin
                                    stat_wr = bus_we;
                                    if (!bus_we) rdata_d = stat_word;
                                end
                                2'd2: begin
                                    ue_rd = !bus_we;
                                    if (!bus_we) rdata_d = ue_word;
                                end
                                default: rdata_d = '0;
                            endcase
                        end
                        default: rdata_d = '0;
                    endcase
                end
            end
            ST_LOOK: begin
                state_d   = ST_RESP;
                load_resp = 1'b1;
                if (rq_region == RG_CHK) begin
                    rdata_d = {{(DATA_W-CHK_W){1'b0}}, st_rchk};
                end else begin
                    err_d   = ecc_on && dec_res.ded;
                    sec_evt = ecc_on && dec_res.sec;
                    ded_evt = err_d;
                    if (r_we) begin
                        enc_din  = merged;
                        st_wdata = merged;
                        st_wchk  = enc_chk;
                        if (!err_d) begin
                            st_we_data = 1'b1;
                            st_we_chk  = 1'b1;
                        end
                    end else begin
                        rdata_d = base;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            rq_region <= RG_DATA;
            r_we      <= 1'b0;
            r_word    <= '0;
            r_be      <= '0;
            r_wdata   <= '0;
            rdata_q   <= '0;
            err_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                rq_region <= in_region;
                r_we      <= bus_we;
                r_word    <= bus_addr[ADDR_W-1:0];
                r_be      <= bus_be;
                r_wdata   <= bus_wdata;
            end
            if (load_resp) begin
                rdata_q <= rdata_d;
                err_q   <= err_d;
            end
        end
    end

    assign bus_ready = (state_q == ST_RESP);
    assign bus_rdata = rdata_q;
    assign bus_err   = bus_ready && err_q;
endmodule

// File: rtl/ecc_ram_wrapper_chk.sv
module ecc_ram_wrapper_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              accept,
    input logic              bus_we,
    input logic [ADDR_W+1:0] bus_addr,
    input logic [7:0]        bus_be,
    input logic [63:0]       bus_wdata,
    input logic              bus_ready,
    input logic              bus_err,
    input logic              ecc_on,
    input logic [7:0]        sec_cnt
);
    logic [1:0] rgn;
    logic       full_data_wr, slow_data_op, stat_clear;

    assign rgn          = bus_addr[ADDR_W+1:ADDR_W];
    assign full_data_wr = accept && bus_we && rgn == 2'd0 && bus_be == 8'hFF;
    assign slow_data_op = accept && rgn == 2'd0 && !(bus_we && bus_be == 8'hFF);
    assign stat_clear   = accept && bus_we && rgn == 2'd2 && bus_addr[1:0] == 2'd1 && bus_wdata[0];

    assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        bus_ready |=> !bus_ready);

    assert_err_with_ready_R11: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> bus_ready);

    assert_full_write_fast_R1: assert property (@(posedge clk) disable iff (rst)
        full_data_wr |=> bus_ready && !bus_err);

    assert_two_cycle_access_R2: assert property (@(posedge clk) disable iff (rst)
        slow_data_op |=> !bus_ready ##1 bus_ready);

    assert_cnt_saturates_R8: assert property (@(posedge clk) disable iff (rst)
        (sec_cnt == 8'hFF && !stat_clear) |=> sec_cnt == 8'hFF);

    assert_no_err_when_off_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_ready && !ecc_on) |-> !bus_err);
endmodule

bind ecc_ram_wrapper ecc_ram_wrapper_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .accept(accept), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_err(bus_err),
    .ecc_on(ecc_on), .sec_cnt(sec_cnt)
);

// File: tb/test_ecc_ram_wrapper.sv
module test_ecc_ram_wrapper;
    localparam int ADDR_W = 6;
    localparam int AW     = ADDR_W + 2;
    localparam logic [AW-1:0] A_CTRL = 8'h80;
    localparam logic [AW-1:0] A_STAT = 8'h81;
    localparam logic [AW-1:0] A_UE   = 8'h82;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_req = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_be = '0;
    logic [63:0]   bus_wdata = '0;
    logic [63:0]   bus_rdata;
    logic          bus_ready;
    logic          bus_err;

    int checks = 0;
    int errors = 0;
    logic [63:0] last_rd;
    logic        last_err;
    int          last_lat;

    always #10 clk = ~clk;

    ecc_ram_wrapper #(.ADDR_W(ADDR_W)) i_ecc_ram_wrapper (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_err(bus_err)
    );

    function automatic logic [AW-1:0] da(input int w);
        return AW'(w);
    endfunction
    function automatic logic [AW-1:0] ca(input int w);
        return 8'h40 | AW'(w);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic xfer(input logic we, input logic [AW-1:0] a,
                        input logic [7:0] be, input logic [63:0] wd);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = wd;
        last_lat = 0;
        do begin
            @(negedge clk);
            last_lat++;
        end while (!bus_ready && last_lat < 20);
        last_rd  = bus_rdata;
        last_err = bus_err;
        bus_req  = 1'b0;
        bus_we   = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [63:0] d);
        xfer(1'b1, a, 8'hFF, d);
    endtask
    task automatic rd(input logic [AW-1:0] a);
        xfer(1'b0, a, 8'h00, 64'h0);
    endtask

    task automatic flip_chk(input int w, input logic [7:0] mask);
        logic [7:0] c;
        wr(A_CTRL, 64'hA5);
        rd(ca(w));
        c = last_rd[7:0];
        xfer(1'b1, ca(w), 8'h01, {56'h0, c ^ mask});
        wr(A_CTRL, 64'h5A);
    endtask

    task automatic t_reset;
        rd(A_CTRL); chk("R7", "reset ctrl", last_rd, 64'h5A);
        chk("R11", "reg read latency", 64'(last_lat), 64'd1);
        rd(A_STAT); chk("R8", "reset status", last_rd, 64'h0);
        rd(A_UE);   chk("R9", "reset fault addr", last_rd, 64'h0);
    endtask

    task automatic t_full_rw;
        logic [63:0] pat [3];
        int          wd  [3];
        pat[0] = 64'h0; pat[1] = '1; pat[2] = 64'h00000000ABCDEF23;
        wd[0] = 0; wd[1] = 31; wd[2] = 63;
        for (int i = 0; i < 3; i++) begin
            wr(da(wd[i]), pat[i]);
            chk("R1", "full write latency", 64'(last_lat), 64'd1);
            chk("R1", "full write err", 64'(last_err), 64'd0);
        end
        for (int i = 0; i < 3; i++) begin
            rd(da(wd[i]));
            chk("R4", "read data", last_rd, pat[i]);
            chk("R4", "read latency", 64'(last_lat), 64'd2);
        end
    endtask

    task automatic t_partial;
        wr(da(2), 64'h1122334455667788);
        xfer(1'b1, da(2), 8'h05, 64'hA1A2A3A4A5A6A7A8);
        chk("R2", "rmw latency", 64'(last_lat), 64'd2);
        chk("R2", "rmw err", 64'(last_err), 64'd0);
        rd(da(2)); chk("R2", "merge lanes 0,2", last_rd, 64'h1122334455A677A8);
        xfer(1'b1, da(2), 8'hF0, 64'hDEADBEEF00000000);
        rd(da(2)); chk("R2", "merge upper lanes", last_rd, 64'hDEADBEEF55A677A8);
    endtask

    task automatic t_sec;
        wr(da(3), 64'h0F0F0F0F12345678);
        flip_chk(3, 8'h01);
        rd(da(3));
        chk("R4", "single fault corrected", last_rd, 64'h0F0F0F0F12345678);
        chk("R6", "single check flip no err", 64'(last_err), 64'd0);
        rd(A_STAT); chk("R8", "status after one fix", last_rd, 64'h0101);
        rd(da(3));
        rd(A_STAT); chk("R4", "fault not written back", last_rd, 64'h0201);
        wr(A_STAT, 64'h1);
        rd(A_STAT); chk("R8", "w1c corrected flag", last_rd, 64'h0);
    endtask

    task automatic t_ded;
        wr(da(4), 64'hCAFEF00D00C0FFEE);
        flip_chk(4, 8'h03);
        wr(A_CTRL, 64'h55);
        rd(da(4));
        chk("R10", "raw read", last_rd, 64'hCAFEF00D00C0FFEE);
        chk("R10", "no err when off", 64'(last_err), 64'd0);
        rd(A_STAT); chk("R10", "status untouched", last_rd, 64'h0);
        wr(A_CTRL, 64'h5A);
        rd(da(4)); chk("R5", "double fault err", 64'(last_err), 64'd1);
        rd(A_STAT); chk("R8", "sticky double flag", last_rd, 64'h2);
        rd(A_UE); chk("R9", "fault address", last_rd, 64'h80000004);
        rd(A_UE); chk("R9", "cleared by read", last_rd, 64'h0);
        rd(da(4)); chk("R5", "fault persists", 64'(last_err), 64'd1);
        rd(A_UE);
        xfer(1'b1, da(4), 8'h01, 64'hFF);
        chk("R3", "rmw on bad word err", 64'(last_err), 64'd1);
        chk("R3", "rmw err latency", 64'(last_lat), 64'd2);
        rd(A_UE); chk("R3", "rmw fault logged", last_rd, 64'h80000004);
        wr(A_CTRL, 64'h55);
        rd(da(4)); chk("R3", "rmw write dropped", last_rd, 64'hCAFEF00D00C0FFEE);
        wr(A_CTRL, 64'h5A);
        wr(da(4), 64'h0123456789ABCDEF);
        rd(da(4));
        chk("R1", "full write repairs", 64'(last_err), 64'd0);
        chk("R1", "repaired data", last_rd, 64'h0123456789ABCDEF);
        wr(A_STAT, 64'h2);
        rd(A_STAT); chk("R8", "w1c double flag", last_rd, 64'h0);
    endtask

    task automatic t_chk_guard;
        logic [7:0] c;
        wr(da(5), 64'h5555AAAA5555AAAA);
        rd(ca(5)); c = last_rd[7:0];
        chk("R11", "check read latency", 64'(last_lat), 64'd2);
        wr(A_CTRL, 64'hAA);
        xfer(1'b1, ca(5), 8'h01, {56'h0, c ^ 8'h03});
        chk("R11", "check write latency", 64'(last_lat), 64'd1);
        rd(ca(5)); chk("R6", "ignored while checking on", last_rd, {56'h0, c});
        wr(A_CTRL, 64'h55);
        xfer(1'b1, ca(5), 8'h01, {56'h0, c ^ 8'h03});
        rd(ca(5)); chk("R6", "ignored while write mode off", last_rd, {56'h0, c});
        wr(A_CTRL, 64'hA5);
        xfer(1'b1, ca(5), 8'h00, {56'h0, c ^ 8'h03});
        rd(ca(5)); chk("R6", "ignored without lane 0", last_rd, {56'h0, c});
        wr(A_CTRL, 64'h5A);
        rd(da(5)); chk("R6", "word intact", 64'(last_err), 64'd0);
    endtask

    task automatic t_ctrl_keys;
        wr(A_CTRL, 64'h33);
        rd(A_CTRL); chk("R7", "bad keys keep", last_rd, 64'h5A);
        wr(A_CTRL, 64'hA5);
        rd(A_CTRL); chk("R7", "both flipped", last_rd, 64'hA5);
        wr(A_CTRL, 64'h7C);
        rd(A_CTRL); chk("R7", "bad keys keep again", last_rd, 64'hA5);
        wr(A_CTRL, 64'h5A);
    endtask

    task automatic t_sat;
        wr(da(6), 64'h8000000000000001);
        flip_chk(6, 8'h80);
        wr(A_STAT, 64'h3);
        for (int i = 0; i < 260; i++) rd(da(6));
        chk("R4", "corrected after many reads", last_rd, 64'h8000000000000001);
        rd(A_STAT); chk("R8", "counter saturates", last_rd, 64'hFF01);
        wr(A_STAT, 64'h1);
        rd(A_STAT); chk("R8", "counter cleared", last_rd, 64'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_full_rw;
        t_partial;
        t_sec;
        t_ded;
        t_chk_guard;
        t_ctrl_keys;
        t_sat;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R11 watchdog: actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule